// File: doc/BRIEF.md
# Instruction Cache Entry Parity Checker

This block inspects the parity protection of a single instruction-cache way entry after it has been read out of the arrays. The tag side receives a 32-bit upper tag word and a 64-bit lower tag word. It confirms that the valid flag agrees with its duplicate. For a valid entry it also confirms that the two virtual-tag parity fields agree with the bit ranges they cover. The data side receives a 32-bit side word that carries the parity and predecode bits, along with two 32-bit instructions. It checks four even byte-parity bits per instruction and one parity bit over the predecode byte.

Every check is combinational. When the error handler raises a one-cycle check strobe, a tag-error flag, a data-error flag and the least-to-most-recently-used way order of the set are captured together. They then hold until the next strobe. Error-handling logic uses the flags to decide whether the indicated kind of fault is really present in the entry.

Top module: `ic_parity_chk`

## Requirements
- R1: When upper-tag bit 29 (valid) differs from upper-tag bit 27 (its duplicate), a strobed check sets `tag_err`.
- R2: When upper-tag bits 29 and 27 are both 0, the lower tag word has no effect: a strobed check clears `tag_err` whatever the lower word holds.
- R3: For a valid entry, lower-tag bit 10 must equal the XOR of lower-tag bits 23:0 with bits 11 and 10 excluded. A mismatch sets `tag_err`.
- R4: For a valid entry, lower-tag bit 11 must equal the XOR of lower-tag bits 63:24. A mismatch sets `tag_err`.
- R5: Side-word bits 7:4 hold the even byte parity of instruction A. Bit 7 covers instruction bits 31:24, bit 6 covers 23:16, bit 5 covers 15:8 and bit 4 covers 7:0. Any mismatch sets `data_err`.
- R6: Side-word bits 3:0 hold the even byte parity of instruction B, using the same byte-to-bit order (bit 3 for bits 31:24 down to bit 0 for bits 7:0). Any mismatch sets `data_err`.
- R7: Side-word bit 16 must equal the XOR of the predecode byte in side-word bits 15:8. A mismatch sets `data_err`.
- R8: `lru_order` captures upper-tag bits 21:14 on a strobe. Its bits 1:0 name the least recently used way and its bits 7:6 name the most recently used way.
- R9: All outputs change only on the clock edge at which `chk_en` is high. They show the new result from the next cycle and hold it while `chk_en` is low.
- R10: While `rst_n` is low, `tag_err`, `data_err` and `lru_order` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_en | input | 1 | Check strobe; captures results at this edge |
| tag_hi | input | 32 | Upper tag word (valid, valid copy, LRU field) |
| tag_lo | input | 64 | Lower tag word (virtual tag and its two parity bits) |
| side_word | input | 32 | Instruction parity nibbles, predecode byte and its parity |
| inst_a | input | 32 | First instruction of the data pair |
| inst_b | input | 32 | Second instruction of the data pair |
| tag_err | output | 1 | Registered tag parity error flag |
| data_err | output | 1 | Registered data parity error flag |
| lru_order | output | 8 | Registered way order, LRU in low pair, MRU in high pair |

## Verification
The bench uses the default parameters: 32-bit instructions split into four byte lanes, a 64-bit lower tag split at bit 24, and four ways with 2-bit way numbers. These values put every byte lane of both instructions within reach. They also put both sides of the tag split and both excluded parity positions within reach, so single-bit faults can be placed at each boundary, including bits 10, 11, 23 and 24. With the strobe held low, faults injected into the inputs show that the captured result does not move.

// File: rtl/ic_par_pkg.sv
package ic_par_pkg;

    // geometry of the protected entry
    localparam int IC_WAYS      = 4;
    localparam int IC_WAY_IDX_W = $clog2(IC_WAYS);
    localparam int IC_LRU_W     = IC_WAYS * IC_WAY_IDX_W;

    // registered outcome of one check
    typedef struct packed {
        logic                tag_err;
        logic                data_err;
        logic [IC_LRU_W-1:0] lru;
    } ic_chk_res_t;

endpackage

// File: rtl/ic_group_parity.sv
// Even parity of each GRP_W-bit group of a word; group g lands in bit g,
// so the most significant group drives the most significant parity bit.
module ic_group_parity #(
    parameter int WORD_W = 32,
    parameter int GRP_W  = 8,
    localparam int NGRP  = WORD_W / GRP_W
) (
    input  logic [WORD_W-1:0] word,
    output logic [NGRP-1:0]   par
);
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign par[g] = ^word[g*GRP_W +: GRP_W];
    end
endmodule

// File: rtl/ic_tag_check.sv
module ic_tag_check #(
    parameter int HI_W      = 32,
    parameter int LO_W      = 64,
    parameter int VLD_BIT   = 29,
    parameter int VLD_CP    = 27,
    parameter int LO_SPLIT  = 24,
    parameter int PAR0_BIT  = 10,
    parameter int PAR1_BIT  = 11
) (
    input  logic [HI_W-1:0] tag_hi,
    input  logic [LO_W-1:0] tag_lo,
    output logic            err
);
    localparam int UPPER_W = LO_W - LO_SPLIT;

    logic                vld;
    logic                vld_bad;
    logic [LO_SPLIT-1:0] low_mask;
    logic                low_bad;
    logic                up_bad;
    logic                unused_hi;

    // both parity bits are removed from the low range they sit in
    always_comb begin
        low_mask           = '1;
        low_mask[PAR0_BIT] = 1'b0;
        low_mask[PAR1_BIT] = 1'b0;
    end

    assign vld     = tag_hi[VLD_BIT];
    assign vld_bad = vld ^ tag_hi[VLD_CP];
    assign low_bad = tag_lo[PAR0_BIT] ^ (^(tag_lo[LO_SPLIT-1:0] & low_mask));
    assign up_bad  = tag_lo[PAR1_BIT] ^ (^tag_lo[LO_W-1 -: UPPER_W]);
    assign err     = vld_bad | (vld & (low_bad | up_bad));

    assign unused_hi = ^tag_hi;
endmodule

// File: rtl/ic_data_check.sv
module ic_data_check #(
    parameter int INST_W   = 32,
    parameter int BYTE_W   = 8,
    parameter int SIDE_W   = 32,
    parameter int PDEC_LSB = 8,
    parameter int PDEC_PAR = 16
) (
    input  logic [SIDE_W-1:0] side_word,
    input  logic [INST_W-1:0] inst_a,
    input  logic [INST_W-1:0] inst_b,
    output logic              err
);
    localparam int NIB_W = INST_W / BYTE_W;

    logic [NIB_W-1:0] par_a;
    logic [NIB_W-1:0] par_b;
    logic             a_bad;
    logic             b_bad;
    logic             pdec_bad;
    logic             unused_side;

    ic_group_parity #(.WORD_W(INST_W), .GRP_W(BYTE_W)) u_par_a (
        .word (inst_a),
        .par  (par_a)
    );

    ic_group_parity #(.WORD_W(INST_W), .GRP_W(BYTE_W)) u_par_b (
        .word (inst_b),
        .par  (par_b)
    );

    // instruction B nibble at the bottom, instruction A just above it
    assign b_bad    = |(par_b ^ side_word[0 +: NIB_W]);
    assign a_bad    = |(par_a ^ side_word[NIB_W +: NIB_W]);
    assign pdec_bad = side_word[PDEC_PAR] ^ (^side_word[PDEC_LSB +: BYTE_W]);
    assign err      = a_bad | b_bad | pdec_bad;

    assign unused_side = ^side_word;
endmodule

// File: rtl/ic_parity_chk.sv
module ic_parity_chk
    import ic_par_pkg::*;
#(
    parameter int TAG_HI_W = 32,
    parameter int TAG_LO_W = 64,
    parameter int INST_W   = 32,
    parameter int BYTE_W   = 8,
    parameter int SIDE_W   = 32,
    parameter int VLD_BIT  = 29,
    parameter int VLD_CP   = 27,
    parameter int LO_SPLIT = 24,
    parameter int PAR0_BIT = 10,
    parameter int PAR1_BIT = 11,
    parameter int PDEC_LSB = 8,
    parameter int PDEC_PAR = 16,
    parameter int LRU_LSB  = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                chk_en,
    input  logic [TAG_HI_W-1:0] tag_hi,
    input  logic [TAG_LO_W-1:0] tag_lo,
    input  logic [SIDE_W-1:0]   side_word,
    input  logic [INST_W-1:0]   inst_a,
    input  logic [INST_W-1:0]   inst_b,
    output logic                tag_err,
    output logic                data_err,
    output logic [IC_LRU_W-1:0] lru_order
);

    logic        tag_bad;
    logic        data_bad;
    ic_chk_res_t res_d;
    ic_chk_res_t res_q;

    ic_tag_check #(
        .HI_W     (TAG_HI_W),
        .LO_W     (TAG_LO_W),
        .VLD_BIT  (VLD_BIT),
        .VLD_CP   (VLD_CP),
        .LO_SPLIT (LO_SPLIT),
        .PAR0_BIT (PAR0_BIT),
        .PAR1_BIT (PAR1_BIT)
    ) u_tag (
        .tag_hi (tag_hi),
        .tag_lo (tag_lo),
        .err    (tag_bad)
    );

    ic_data_check #(
        .INST_W   (INST_W),
        .BYTE_W   (BYTE_W),
        .SIDE_W   (SIDE_W),
        .PDEC_LSB (PDEC_LSB),
        .PDEC_PAR (PDEC_PAR)
    ) u_data (
        .side_word (side_word),
        .inst_a    (inst_a),
        .inst_b    (inst_b),
        .err       (data_bad)
    );

    always_comb begin
        res_d = res_q;
        if (chk_en) begin
            res_d.tag_err  = tag_bad;
            res_d.data_err = data_bad;
            res_d.lru      = tag_hi[LRU_LSB +: IC_LRU_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign tag_err   = res_q.tag_err;
    assign data_err  = res_q.data_err;
    assign lru_order = res_q.lru;

endmodule

// File: rtl/ic_parity_chk_sva.sv
module ic_parity_chk_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        chk_en,
    input logic [31:0] tag_hi,
    input logic [31:0] side_word,
    input logic        tag_err,
    input logic        data_err,
    input logic [7:0]  lru_order
);
    // R1
    vld_copy_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && (tag_hi[29] != tag_hi[27])) |=> tag_err);

    // R2
    invalid_entry_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && !tag_hi[29] && !tag_hi[27]) |=> !tag_err);

    // R7
    predecode_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && (^side_word[16:8])) |=> data_err);

    // R8
    lru_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en |=> (lru_order == $past(tag_hi[21:14])));

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_en |=> ($stable(tag_err) && $stable(data_err) && $stable(lru_order)));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!tag_err && !data_err && lru_order == 8'h00));
endmodule

bind ic_parity_chk ic_parity_chk_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_en    (chk_en),
    .tag_hi    (tag_hi),
    .side_word (side_word),
    .tag_err   (tag_err),
    .data_err  (data_err),
    .lru_order (lru_order)
);

// File: tb/ic_parity_chk_test.sv
`timescale 1ns/1ps
module ic_parity_chk_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_en = 1'b0;
    logic [31:0] tag_hi = '0;
    logic [63:0] tag_lo = '0;
    logic [31:0] side_word = '0;
    logic [31:0] inst_a = '0;
    logic [31:0] inst_b = '0;
    logic        tag_err;
    logic        data_err;
    logic [7:0]  lru_order;

    int checks = 0;
    int errors = 0;

    // reference state
    bit       m_te = 1'b0;
    bit       m_de = 1'b0;
    bit [7:0] m_lru = 8'h00;

    always #4 clk = ~clk;

    ic_parity_chk uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .chk_en    (chk_en),
        .tag_hi    (tag_hi),
        .tag_lo    (tag_lo),
        .side_word (side_word),
        .inst_a    (inst_a),
        .inst_b    (inst_b),
        .tag_err   (tag_err),
        .data_err  (data_err),
        .lru_order (lru_order)
    );

    function automatic bit span_par(input logic [63:0] w, input int hi, input int lo,
                                    input int skip0, input int skip1);
        int n = 0;
        for (int i = lo; i <= hi; i++)
            if (i != skip0 && i != skip1 && w[i]) n++;
        return n[0];
    endfunction

    function automatic bit [3:0] lane_par(input logic [31:0] w);
        bit [3:0] r;
        for (int k = 0; k < 4; k++)
            r[k] = span_par({32'h0, w}, k*8+7, k*8, -1, -1);
        return r;
    endfunction

    task automatic model_eval();
        bit v = tag_hi[29];
        bit t = (v != tag_hi[27]);
        bit d;
        if (v) begin
            if (tag_lo[10] != span_par(tag_lo, 23, 0, 10, 11)) t = 1'b1;
            if (tag_lo[11] != span_par(tag_lo, 63, 24, -1, -1)) t = 1'b1;
        end
        d = (side_word[7:4] != lane_par(inst_a)) ||
            (side_word[3:0] != lane_par(inst_b)) ||
            (side_word[16] != span_par({32'h0, side_word}, 15, 8, -1, -1));
        m_te  = t;
        m_de  = d;
        m_lru = tag_hi[21:14];
    endtask

    task automatic compare(input string req);
        checks++;
        if (tag_err !== m_te || data_err !== m_de || lru_order !== m_lru) begin
            errors++;
            $display("FAIL %s: actual te=%0b de=%0b lru=%02h expected te=%0b de=%0b lru=%02h",
                     req, tag_err, data_err, lru_order, m_te, m_de, m_lru);
        end
    endtask

    // called at a negedge; inputs are already set
    task automatic step(input bit en, input string req);
        chk_en = en;
        @(posedge clk);
        if (en) model_eval();
        @(negedge clk);
        chk_en = 1'b0;
        compare(req);
    endtask

    // build an entry whose every protection bit is correct
    task automatic make_good();
        tag_hi = $urandom;
        tag_hi[29] = 1'b1;
        tag_hi[27] = 1'b1;
        tag_lo = {$urandom, $urandom};
        tag_lo[10] = span_par(tag_lo, 23, 0, 10, 11);
        tag_lo[11] = span_par(tag_lo, 63, 24, -1, -1);
        inst_a = $urandom;
        inst_b = $urandom;
        side_word = $urandom;
        side_word[7:4] = lane_par(inst_a);
        side_word[3:0] = lane_par(inst_b);
        side_word[16] = ^side_word[15:8];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tag_hi = '1;
        tag_lo = '1;
        side_word = '1;
        chk_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R10 reset");
        chk_en = 1'b0;
        rst_n = 1'b1;

        make_good();
        step(1'b1, "R8 clean entry");
        make_good(); tag_hi[27] = 1'b0;
        step(1'b1, "R1 valid copy low");
        make_good(); tag_hi[29] = 1'b0;
        step(1'b1, "R1 valid low copy high");
        make_good(); tag_hi[29] = 1'b0; tag_hi[27] = 1'b0; tag_lo[5] ^= 1'b1; tag_lo[40] ^= 1'b1;
        step(1'b1, "R2 invalid ignores lower tag");
        foreach (tag_lo[i]) begin
            make_good();
            tag_lo[i] ^= 1'b1;
            step(1'b1, (i < 24 && i != 11) ? "R3 lower tag low range" : "R4 lower tag high range");
        end
        foreach (inst_a[i]) begin
            make_good(); inst_a[i] ^= 1'b1;
            step(1'b1, "R5 instruction A lane");
        end
        for (int i = 4; i < 8; i++) begin
            make_good(); side_word[i] ^= 1'b1;
            step(1'b1, "R5 parity nibble A");
        end
        foreach (inst_b[i]) begin
            make_good(); inst_b[i] ^= 1'b1;
            step(1'b1, "R6 instruction B lane");
        end
        for (int i = 0; i < 4; i++) begin
            make_good(); side_word[i] ^= 1'b1;
            step(1'b1, "R6 parity nibble B");
        end
        for (int i = 8; i < 17; i++) begin
            make_good(); side_word[i] ^= 1'b1;
            step(1'b1, "R7 predecode");
        end
        make_good(); side_word[31:17] = ~side_word[31:17];
        step(1'b1, "R7 bits above predecode parity");
        make_good(); tag_hi[27] = 1'b0;
        step(1'b1, "R1 set before hold");
        make_good(); tag_hi[21:14] = 8'h1B;
        step(1'b0, "R9 hold with clean inputs");
        tag_hi[27] = 1'b0; inst_a ^= 32'h1;
        step(1'b0, "R9 hold with faulty inputs");
        make_good(); tag_hi[21:14] = 8'hE4;
        step(1'b1, "R8 lru order");
        for (int n = 0; n < 300; n++) begin
            make_good();
            if (n % 3 == 0) tag_lo[$urandom_range(63, 0)] ^= 1'b1;
            if (n % 4 == 0) side_word[$urandom_range(16, 0)] ^= 1'b1;
            if (n % 5 == 0) tag_hi[29] = $urandom_range(1, 0);
            step(n % 7 != 0, "R9 mixed random");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule